// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This block is a down-counting timer built from one count register and one companion register, both of a parameterised width that defaults to 16 bits. A 3-bit mode input gives the pair one of three roles:

- **Event counter with auto-reload.** The counter steps on edges of the timer pin.
- **Interval timer with auto-reload.** The counter steps on the instruction-cycle tick. One variant of this mode inverts a pin output on every underflow.
- **Free-running timer with input capture.** The companion register records the counter value on a chosen edge of the pin.

A sticky interrupt-pending flag reports underflows in the reload roles and edges in the capture role. The flag stays set until the host clears it with a strobe.

Software reaches both registers through a small byte-wide port. The port takes a 2-bit address: the high address bit picks the register and the low bit picks the byte. A run input starts and stops all counting. The pin input must already be synchronised to the clock. The interrupt controller that consumes the pending flag sits outside the block.

Top module: `multimode_timer`

## Requirements
- R1: After reset the count register, the companion register, the pending flag and the pin output all read zero.
- R2: Register address map (two address bits): 0 is count low byte, 1 is count high byte, 2 is companion low byte, 3 is companion high byte. A write replaces that byte on the next clock edge. The read data shows the addressed byte combinationally.
- R3: In modes 100, 101, 110 and 111 the count register decrements by one for each cycle in which both the tick input and the run input are 1. It holds its value when run is 0 or when no tick is present.
- R4: In the reload modes (000, 001, 100, 101), a count event while the count register is zero loads the companion value instead of decrementing. The reload period is therefore the companion value plus one.
- R5: In mode 101 the pin output inverts on every underflow. The pin output enable is 1 only in mode 101, and the pin output holds its value in every other mode.
- R6: Mode 000 counts on a rising pin edge and mode 001 counts on a falling pin edge. In both modes the tick input and the other edge have no effect.
- R7: Mode 110 captures on a rising pin edge and mode 111 captures on a falling pin edge. On the selected edge the current count value is copied into the companion register. In these modes the count register wraps from 0x0000 to 0xFFFF.
- R8: The pending flag sets on an underflow in the reload modes and on the selected edge in the capture modes. Once set it stays set until the clear strobe. If a set and a clear arrive in the same cycle, the set wins.
- R9: Mode codes 010 and 011 freeze the count register and raise no interrupt.
- R10: A host write to either count byte takes priority over a count event in the same cycle. The byte that was not written keeps its value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | Instruction-cycle tick, one clock wide |
| tio_in | input | 1 | Synchronised timer pin input |
| run | input | 1 | Counting enable |
| mode | input | 3 | Mode code |
| irq_clr | input | 1 | Clears the pending flag |
| reg_we | input | 1 | Byte write strobe |
| reg_addr | input | 2 | Register and byte select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed byte |
| tio_out | output | 1 | Timer pin output value |
| tio_oe | output | 1 | Timer pin output enable |
| irq_pend | output | 1 | Sticky interrupt-pending flag |

## Verification
The bench builds the block with its default widths: a 16-bit counter and an 8-bit byte port. With these widths the 0x0000-to-0xFFFF wrap in the capture modes can be reached within a few ticks by preloading a small count. Small companion values bring reload underflows within reach in a handful of ticks, so every mode code can be driven through its edge, tick, underflow and capture cases. The 0x0100 preload, written in the same cycle as a tick, separates a merged byte write from a lane-by-lane update.

// File: rtl/mmt_pkg.sv
`timescale 1ns/1ps
package mmt_pkg;

   typedef enum logic [2:0] {
      MODE_EXT_RISE   = 3'b000,
      MODE_EXT_FALL   = 3'b001,
      MODE_RSV_A      = 3'b010,
      MODE_RSV_B      = 3'b011,
      MODE_TMR_RELOAD = 3'b100,
      MODE_TMR_TOGGLE = 3'b101,
      MODE_CAP_RISE   = 3'b110,
      MODE_CAP_FALL   = 3'b111
   } mode_e;

   typedef struct packed {
      logic active;     // mode code is legal
      logic ext_src;    // count on pin edges instead of ticks
      logic reload;     // underflow reloads from companion
      logic toggle;     // pin output inverts on underflow
      logic capture;    // edge copies count into companion
      logic fall_edge;  // selected edge is falling
   } mode_ctl_t;

endpackage

// File: rtl/mmt_mode_dec.sv
`timescale 1ns/1ps
module mmt_mode_dec
   import mmt_pkg::*;
(
   input  logic [2:0] mode_i,
   output mode_ctl_t  ctl_o
);

   always_comb begin
      ctl_o = '0;
      case (mode_e'(mode_i))
         MODE_EXT_RISE: begin
            ctl_o.active  = 1'b1;
            ctl_o.ext_src = 1'b1;
            ctl_o.reload  = 1'b1;
         end
         MODE_EXT_FALL: begin
            ctl_o.active    = 1'b1;
            ctl_o.ext_src   = 1'b1;
            ctl_o.reload    = 1'b1;
            ctl_o.fall_edge = 1'b1;
         end
         MODE_TMR_RELOAD: begin
            ctl_o.active = 1'b1;
            ctl_o.reload = 1'b1;
         end
         MODE_TMR_TOGGLE: begin
            ctl_o.active = 1'b1;
            ctl_o.reload = 1'b1;
            ctl_o.toggle = 1'b1;
         end
         MODE_CAP_RISE: begin
            ctl_o.active  = 1'b1;
            ctl_o.capture = 1'b1;
         end
         MODE_CAP_FALL: begin
            ctl_o.active    = 1'b1;
            ctl_o.capture   = 1'b1;
            ctl_o.fall_edge = 1'b1;
         end
         default: ctl_o = '0;   // reserved codes
      endcase
   end

endmodule

// File: rtl/mmt_edge_det.sv
`timescale 1ns/1ps
module mmt_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   logic pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_i;
   end

   assign rise_o = pin_i & ~pin_q;
   assign fall_o = ~pin_i & pin_q;

endmodule

// File: rtl/mmt_wreg.sv
`timescale 1ns/1ps
module mmt_wreg #(
   parameter int unsigned W  = 16,
   parameter int unsigned BW = 8,
   localparam int unsigned NB = W / BW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] byte_we,
   input  logic [BW-1:0] wdata,
   input  logic          upd_en,
   input  logic [W-1:0]  upd_val,
   output logic [W-1:0]  q
);

   // Any host byte write blocks the internal update for the whole register.
   logic host_hit;
   assign host_hit = |byte_we;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i*BW +: BW] <= '0;
         else if (byte_we[i])
            q[i*BW +: BW] <= wdata;
         else if (upd_en && !host_hit)
            q[i*BW +: BW] <= upd_val[i*BW +: BW];
      end
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      byte_we[0] |=> q[BW-1:0] == $past(wdata)); // R2

endmodule

// File: rtl/multimode_timer.sv
`timescale 1ns/1ps
module multimode_timer
   import mmt_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned BUS_W = 8,
   localparam int unsigned NB     = CNT_W / BUS_W,
   localparam int unsigned IDX_W  = (NB > 1) ? $clog2(NB) : 1,
   localparam int unsigned ADDR_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_tick,
   input  logic              tio_in,
   input  logic              run,
   input  logic [2:0]        mode,
   input  logic              irq_clr,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic              tio_out,
   output logic              tio_oe,
   output logic              irq_pend
);

   // ---------------- elaboration checks ----------------
   if (CNT_W % BUS_W != 0) begin : g_bad_ratio
      $error("CNT_W must be a whole number of bus bytes");
   end
   if (NB < 2 || (1 << IDX_W) != NB) begin : g_bad_count
      $error("CNT_W/BUS_W must be a power of two of at least 2");
   end

   // ---------------- decode and edges ----------------
   mode_ctl_t ctl;
   logic      pin_rise, pin_fall, edge_sel;

   mmt_mode_dec u_dec (.mode_i(mode), .ctl_o(ctl));

   mmt_edge_det u_edge (
      .clk(clk), .rst_n(rst_n), .pin_i(tio_in),
      .rise_o(pin_rise), .fall_o(pin_fall)
   );

   assign edge_sel = ctl.fall_edge ? pin_fall : pin_rise;

   // ---------------- host byte strobes ----------------
   logic [IDX_W-1:0] byte_idx;
   logic             sel_r1;
   logic [NB-1:0]    t1_we, r1_we;

   assign byte_idx = reg_addr[IDX_W-1:0];
   assign sel_r1   = reg_addr[ADDR_W-1];

   for (genvar i = 0; i < NB; i++) begin : g_we
      assign t1_we[i] = reg_we && !sel_r1 && (byte_idx == IDX_W'(i));
      assign r1_we[i] = reg_we &&  sel_r1 && (byte_idx == IDX_W'(i));
   end

   // ---------------- count datapath ----------------
   logic [CNT_W-1:0] t1_q, r1_q, t1_next;
   logic             count_en, underflow, cap_ev, irq_set;

   assign count_en  = ctl.active && run && (ctl.ext_src ? edge_sel : cyc_tick);
   assign underflow = count_en && (t1_q == '0);
   assign t1_next   = (underflow && ctl.reload) ? r1_q : t1_q - 1'b1;
   assign cap_ev    = ctl.capture && edge_sel;
   assign irq_set   = (ctl.reload && underflow) || cap_ev;

   mmt_wreg #(.W(CNT_W), .BW(BUS_W)) u_t1 (
      .clk(clk), .rst_n(rst_n), .byte_we(t1_we), .wdata(reg_wdata),
      .upd_en(count_en), .upd_val(t1_next), .q(t1_q)
   );

   mmt_wreg #(.W(CNT_W), .BW(BUS_W)) u_r1 (
      .clk(clk), .rst_n(rst_n), .byte_we(r1_we), .wdata(reg_wdata),
      .upd_en(cap_ev), .upd_val(t1_q), .q(r1_q)
   );

   // ---------------- read mux ----------------
   logic [CNT_W-1:0] rd_word;
   assign rd_word   = sel_r1 ? r1_q : t1_q;
   assign reg_rdata = rd_word[byte_idx*BUS_W +: BUS_W];

   // ---------------- flag and pin ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_pend <= 1'b0;
      else if (irq_set) irq_pend <= 1'b1;
      else if (irq_clr) irq_pend <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       tio_out <= 1'b0;
      else if (ctl.toggle && underflow) tio_out <= ~tio_out;
   end

   assign tio_oe = ctl.toggle;

   // ---------------- assertions ----------------
   AST_RUN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !(|t1_we)) |=> t1_q == $past(t1_q)); // R3

   AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && ctl.reload && !(|t1_we)) |=> t1_q == $past(r1_q)); // R4

   AST_TIO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tio_oe |=> tio_out == $past(tio_out)); // R5

   AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ev && !(|r1_we)) |=> r1_q == $past(t1_q)); // R7

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && !irq_clr) |=> irq_pend); // R8

   AST_RSV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.active && !(|t1_we)) |=> t1_q == $past(t1_q)); // R9

   AST_RSV_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.active && !irq_pend) |=> !irq_pend); // R9

endmodule

// File: tb/test_multimode_timer.sv
`timescale 1ns/1ps
module test_multimode_timer;

   logic       clk = 1'b0;
   logic       rst_n, cyc_tick, tio_in, run, irq_clr, reg_we;
   logic [2:0] mode;
   logic [1:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic       tio_out, tio_oe, irq_pend;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   multimode_timer i_multimode_timer (
      .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .tio_in(tio_in),
      .run(run), .mode(mode), .irq_clr(irq_clr), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tio_out(tio_out), .tio_oe(tio_oe), .irq_pend(irq_pend)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr8(input logic [1:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic wr16(input logic sel, input logic [15:0] v);
      wr8({sel, 1'b0}, v[7:0]);
      wr8({sel, 1'b1}, v[15:8]);
   endtask

   task automatic rd16(input logic sel, output logic [15:0] v);
      reg_addr = {sel, 1'b0}; #1 v[7:0]  = reg_rdata;
      reg_addr = {sel, 1'b1}; #1 v[15:8] = reg_rdata;
   endtask

   task automatic tick();
      cyc_tick = 1'b1;
      @(negedge clk);
      cyc_tick = 1'b0;
   endtask

   task automatic pin(input logic v);
      tio_in = v;
      @(negedge clk);
   endtask

   task automatic clr_irq();
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
   endtask

   task automatic chk_t1(input string tag, input logic [15:0] exp);
      logic [15:0] v;
      rd16(1'b0, v);
      check(tag, v, exp);
   endtask

   task automatic chk_r1(input string tag, input logic [15:0] exp);
      logic [15:0] v;
      rd16(1'b1, v);
      check(tag, v, exp);
   endtask

   task automatic t_reset();
      chk_t1("R1 count after reset", 16'h0000);
      chk_r1("R1 companion after reset", 16'h0000);
      check("R1 irq after reset", irq_pend, 1'b0);
      check("R1 pin out after reset", tio_out, 1'b0);
      check("R5 oe off in mode 100", tio_oe, 1'b0);
   endtask

   task automatic t_regs();
      wr16(1'b0, 16'h1234);
      wr16(1'b1, 16'hABCD);
      chk_t1("R2 count readback", 16'h1234);
      chk_r1("R2 companion readback", 16'hABCD);
   endtask

   task automatic t_timer();
      mode = 3'b100;
      wr16(1'b0, 16'd5);
      run = 1'b1;
      repeat (3) tick();
      chk_t1("R3 three ticks", 16'd2);
      repeat (4) @(negedge clk);
      chk_t1("R3 no tick holds", 16'd2);
      run = 1'b0;
      repeat (2) tick();
      chk_t1("R3 run low holds", 16'd2);
   endtask

   task automatic t_reload();
      mode = 3'b100;
      wr16(1'b1, 16'd3);
      wr16(1'b0, 16'd1);
      run = 1'b1;
      tick();
      chk_t1("R4 reach zero", 16'd0);
      check("R8 no irq before underflow", irq_pend, 1'b0);
      tick();
      chk_t1("R4 reload value", 16'd3);
      check("R8 irq on underflow", irq_pend, 1'b1);
      clr_irq();
      check("R8 irq cleared", irq_pend, 1'b0);
      repeat (3) tick();
      check("R4 period not yet done", irq_pend, 1'b0);
      tick();
      chk_t1("R4 period of four", 16'd3);
      check("R4 irq after period", irq_pend, 1'b1);
      repeat (3) tick();
      clr_irq();
      cyc_tick = 1'b1; irq_clr = 1'b1;
      @(negedge clk);
      cyc_tick = 1'b0; irq_clr = 1'b0;
      check("R8 set beats clear", irq_pend, 1'b1);
      run = 1'b0;
      clr_irq();
   endtask

   task automatic t_toggle();
      mode = 3'b101;
      #1 check("R5 oe on in mode 101", tio_oe, 1'b1);
      check("R5 pin starts low", tio_out, 1'b0);
      wr16(1'b1, 16'd1);
      wr16(1'b0, 16'd0);
      run = 1'b1;
      tick();
      check("R5 first toggle", tio_out, 1'b1);
      tick();
      check("R5 no toggle mid-period", tio_out, 1'b1);
      tick();
      check("R5 second toggle", tio_out, 1'b0);
      run = 1'b0;
      mode = 3'b100;
      #1 check("R5 oe off again", tio_oe, 1'b0);
      clr_irq();
   endtask

   task automatic t_ext();
      mode = 3'b000;
      wr16(1'b0, 16'd10);
      run = 1'b1;
      repeat (3) tick();
      chk_t1("R6 ticks ignored", 16'd10);
      pin(1'b1);
      chk_t1("R6 rising counts in 000", 16'd9);
      pin(1'b0);
      chk_t1("R6 falling ignored in 000", 16'd9);
      mode = 3'b001;
      pin(1'b1);
      chk_t1("R6 rising ignored in 001", 16'd9);
      pin(1'b0);
      chk_t1("R6 falling counts in 001", 16'd8);
      run = 1'b0;
      mode = 3'b000;
      wr16(1'b0, 16'd0);
      wr16(1'b1, 16'd7);
      clr_irq();
      run = 1'b1;
      pin(1'b1);
      chk_t1("R6 edge underflow reloads", 16'd7);
      check("R8 irq on edge underflow", irq_pend, 1'b1);
      run = 1'b0;
      pin(1'b0);
      clr_irq();
   endtask

   task automatic t_capture();
      mode = 3'b110;
      wr16(1'b0, 16'd2);
      wr16(1'b1, 16'd0);
      clr_irq();
      run = 1'b1;
      repeat (3) tick();
      chk_t1("R7 wrap to FFFF", 16'hFFFF);
      check("R8 no irq on capture-mode wrap", irq_pend, 1'b0);
      pin(1'b1);
      chk_r1("R7 rising capture", 16'hFFFF);
      check("R8 irq on capture edge", irq_pend, 1'b1);
      clr_irq();
      repeat (2) tick();
      pin(1'b0);
      chk_r1("R7 falling ignored in 110", 16'hFFFF);
      check("R8 no irq on other edge", irq_pend, 1'b0);
      mode = 3'b111;
      pin(1'b1);
      tick();
      pin(1'b0);
      chk_r1("R7 falling capture in 111", 16'hFFFC);
      check("R8 irq on falling capture", irq_pend, 1'b1);
      run = 1'b0;
      clr_irq();
   endtask

   task automatic t_reserved();
      mode = 3'b010;
      wr16(1'b0, 16'd0);
      wr16(1'b1, 16'd5);
      run = 1'b1;
      repeat (3) tick();
      pin(1'b1);
      pin(1'b0);
      chk_t1("R9 frozen in 010", 16'd0);
      check("R9 no irq in 010", irq_pend, 1'b0);
      mode = 3'b011;
      repeat (3) tick();
      pin(1'b1);
      pin(1'b0);
      chk_t1("R9 frozen in 011", 16'd0);
      chk_r1("R9 companion untouched", 16'd5);
      check("R9 no irq in 011", irq_pend, 1'b0);
      run = 1'b0;
   endtask

   task automatic t_priority();
      mode = 3'b100;
      wr16(1'b0, 16'h0100);
      run = 1'b1;
      cyc_tick = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h20;
      @(negedge clk);
      cyc_tick = 1'b0; reg_we = 1'b0;
      chk_t1("R10 write beats count", 16'h0120);
      run = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; cyc_tick = 1'b0; tio_in = 1'b0; run = 1'b0;
      irq_clr = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      mode = 3'b100;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_timer();
      t_reload();
      t_toggle();
      t_ext();
      t_capture();
      t_reserved();
      t_priority();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule